// File: doc/BRIEF.md
# Framed Serial Master Without Chip Select

This block is a bit-level serial master for a peripheral that has no chip-select pin. It drives a clock line and a data-out line, and it samples a separate data-in line. Push-pull lines carry the data, but the edges of a frame are marked the way a two-wire bus marks them. An opening mark is a rising edge on data-out while the clock is high. A closing mark is a falling edge on data-out while the clock is high. Ordinary data bits change data-out only while the clock is low, so the peripheral can always tell a mark apart from a data bit.

A caller gives one request. The request holds a bit count, up to `MAX_BYTES*8` transmit bits (the first bit to send is the most significant bit of `tx_data`), and two independent flags that choose the opening mark and the closing mark. A long exchange can therefore be split across several requests: the first opens the frame, the middle ones carry only data, and the last closes it. One half-bit lasts `half_div+1` system clock cycles. With a 100 MHz system clock, a `half_div` of 99 gives a 1 µs half-bit, which is a bit rate of about 500 kHz.

The block returns the bits it received, aligned in the same way as the transmit word. It gives a strobe for every completed byte and a one-cycle completion pulse.

Top module: `framed_serial_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `ser_clk` and `ser_out` are both low; after reset, `busy`, `done` and `rx_data` are zero.
- R2: When `req_begin` is set, the frame opens with `ser_clk` raised while `ser_out` is low for one half-bit, then `ser_out` raised while `ser_clk` stays high for one more half-bit. This rising edge of `ser_out` while the clock is high happens exactly once per request with `req_begin` set and never otherwise.
- R3: Data bits leave in order from `tx_data[MAX_BITS-1]` downward. Each bit is placed on `ser_out` during a clock-low half-bit and is held through a clock-high half-bit. A half-bit is `half_div+1` system clock cycles.
- R4: `ser_in` is sampled in the first cycle after each data-bit falling edge of `ser_clk`. Received bit k (counting from 0) lands in `rx_data[MAX_BITS-1-k]`, and all other bits of `rx_data` are cleared when the request is accepted.
- R5: `rx_byte_stb` pulses for one cycle after every eighth received bit, so a frame of n data bits gives floor(n/8) pulses.
- R6: When `req_end` is set, the frame closes in three half-bits: `ser_out` high with `ser_clk` low, then `ser_clk` high, then `ser_out` low while `ser_clk` is still high. After that `ser_clk` returns low. The falling edge of `ser_out` while the clock is high happens exactly once per request with `req_end` set and never otherwise.
- R7: A request makes exactly n + begin + end rising edges on `ser_clk`, where n is the bit count after R8.
- R8: A bit count above `MAX_BITS` is treated as `MAX_BITS`.
- R9: `busy` rises on the cycle after acceptance and stays high for exactly (2·begin + 2·n + 3·end)·(`half_div`+1) + 1 cycles. `done` pulses for one cycle right after `busy` falls, and at that point `rx_data` already holds every received bit.
- R10: `req_valid` while `busy` is high is ignored and does not change the frame in progress.
- R11: The begin and end flags act independently, so one frame can be opened by one request and closed by a later one. The lines stay low in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (accepted only when not busy) |
| req_begin | input | 1 | Open the frame with a start mark |
| req_end | input | 1 | Close the frame with a stop mark |
| req_nbits | input | CNT_W | Number of data bits, 0 to MAX_BITS (larger values are clamped) |
| tx_data | input | MAX_BITS | Transmit bits, first bit in the MSB |
| half_div | input | DIV_W | Half-bit period minus one, in system clocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | MAX_BITS | Received bits, first bit in the MSB |
| rx_byte_stb | output | 1 | Pulse after each eighth received bit |
| ser_clk | output | 1 | Serial clock line |
| ser_out | output | 1 | Serial data-out line |
| ser_in | input | 1 | Serial data-in line |

## Verification
The sample of the last data bit and the completion of the frame can fall into the same cycle. When no stop mark is requested, the final bit is taken in the one closing cycle in which `busy` is still high. `done` must then show an `rx_data` that already contains that bit. This is provoked with frames that have no closing mark at the shortest half-bit (`half_div` = 0), and with frames that end in a stop mark. The response pattern that the bench drives on `ser_in` is compared with `rx_data` when `done` appears. A second overlap is a new request that arrives while a frame is in progress. The bench pokes `req_valid` with different data in the middle of a frame and checks that the edge counts, the captured bits and the frame length all keep the values of the original request.

// File: rtl/frmser_pkg.sv
package frmser_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_CLK, S_ST_DAT, S_BIT_LO, S_BIT_HI,
    S_SP_DAT, S_SP_CLK, S_SP_DROP, S_FIN
  } phase_e;

  // system clocks per half-bit
  function automatic int unsigned half_cycles(input int unsigned div);
    return div + 1;
  endfunction

  // half-bits spent in one request
  function automatic int unsigned frame_halves(input int unsigned nbits,
                                               input bit b, input bit e);
    return 2 * nbits + (b ? 2 : 0) + (e ? 3 : 0);
  endfunction

  function automatic int unsigned clamp_bits(input int unsigned req,
                                             input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/half_bit_pacer.sv
module half_bit_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt == div)    cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // a half-bit longer than one cycle never ends on two cycles in a row
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/bit_shuttle.sv
module bit_shuttle #(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                adv,
  input  logic                sample,
  input  logic                ser_in,
  output logic                tx_bit,
  output logic [MAX_BITS-1:0] rx_q,
  output logic                byte_stb
);
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [MAX_BITS-1:0] tx_sh;
  logic [CNT_W-1:0]    idx;
  logic [CNT_W-1:0]    slot;

  always_comb slot = CNT_W'(MAX_BITS - 1) - idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_q     <= '0;
      idx      <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (load) begin
        tx_sh <= tx_data;
        rx_q  <= '0;
        idx   <= '0;
      end else begin
        if (adv) tx_sh <= tx_sh << 1;
        if (sample) begin
          rx_q[slot[IDX_W-1:0]] <= ser_in;
          idx      <= idx + 1'b1;
          byte_stb <= (idx[2:0] == 3'd7);
        end
      end
    end
  end

  assign tx_bit = tx_sh[MAX_BITS-1];

  assert_rx_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rx_q == '0));
  assert_byte_follows_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(sample));
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frmser_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_W    = 6,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_begin,
  input  logic             req_end,
  input  logic [CNT_W-1:0] req_nbits,
  input  logic [DIV_W-1:0] half_div,
  input  logic             tick,
  input  logic             tx_bit,
  output logic             run,
  output logic [DIV_W-1:0] div_q,
  output logic             load,
  output logic             adv,
  output logic             sample,
  output logic             busy,
  output logic             done,
  output logic             ser_clk,
  output logic             ser_out
);
  phase_e           state;
  logic             beg_q, end_q;
  logic [CNT_W-1:0] left, nb_q, nb_in;

  always_comb nb_in = CNT_W'(clamp_bits(32'(req_nbits), MAX_BITS));

  // phase that follows the opening mark (or acceptance without one)
  function automatic phase_e body_phase(input logic [CNT_W-1:0] n, input logic e);
    if (n != '0) return S_BIT_LO;
    if (e)       return S_SP_DAT;
    return S_FIN;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      beg_q  <= 1'b0;
      end_q  <= 1'b0;
      left   <= '0;
      nb_q   <= '0;
      div_q  <= '0;
      sample <= 1'b0;
      done   <= 1'b0;
    end else begin
      done   <= (state == S_FIN);
      sample <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          beg_q <= req_begin;
          end_q <= req_end;
          left  <= nb_in;
          nb_q  <= nb_in;
          div_q <= half_div;
          state <= req_begin ? S_ST_CLK : body_phase(nb_in, req_end);
        end
        S_ST_CLK:  if (tick) state <= S_ST_DAT;
        S_ST_DAT:  if (tick) state <= body_phase(left, end_q);
        S_BIT_LO:  if (tick) state <= S_BIT_HI;
        S_BIT_HI:  if (tick) begin
          left   <= left - 1'b1;
          sample <= 1'b1;
          state  <= (left > 1) ? S_BIT_LO : (end_q ? S_SP_DAT : S_FIN);
        end
        S_SP_DAT:  if (tick) state <= S_SP_CLK;
        S_SP_CLK:  if (tick) state <= S_SP_DROP;
        S_SP_DROP: if (tick) state <= S_FIN;
        S_FIN:     state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign load = (state == S_IDLE) && req_valid;
  assign adv  = (state == S_BIT_HI) && tick;
  assign run  = (state != S_IDLE) && (state != S_FIN);
  assign busy = (state != S_IDLE);

  always_comb begin
    ser_clk = (state == S_ST_CLK) || (state == S_ST_DAT) || (state == S_BIT_HI) ||
              (state == S_SP_CLK) || (state == S_SP_DROP);
    unique case (state)
      S_ST_DAT, S_SP_DAT, S_SP_CLK: ser_out = 1'b1;
      S_BIT_LO, S_BIT_HI:           ser_out = tx_bit;
      default:                      ser_out = 1'b0;
    endcase
  end

  // checker: cycles spent in timed phases, compared with the length formula
  int unsigned busy_cyc;
  int unsigned exp_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy_cyc <= 0;
    else if (load)                  busy_cyc <= 0;
    else if (state != S_IDLE)       busy_cyc <= busy_cyc + 1;
  end
  always_comb exp_len = frame_halves(32'(nb_q), beg_q, end_q) * half_cycles(32'(div_q));

  assert_frame_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN) |-> (busy_cyc == exp_len));
  assert_done_after_fin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state) == S_FIN) && !busy);
  assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT_HI && $past(state) == S_BIT_HI) |-> $stable(ser_out));
  assert_count_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left <= CNT_W'(MAX_BITS)));
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!ser_clk && !ser_out));
endmodule

// File: rtl/framed_serial_master.sv
module framed_serial_master #(
  parameter int MAX_BYTES = 4,
  parameter int DIV_W     = 8,
  localparam int MAX_BITS = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_begin,
  input  logic                req_end,
  input  logic [CNT_W-1:0]    req_nbits,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic [DIV_W-1:0]    half_div,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_byte_stb,
  output logic                ser_clk,
  output logic                ser_out,
  input  logic                ser_in
);
  logic             run, tick, load, adv, sample, tx_bit;
  logic [DIV_W-1:0] div_q;

  frame_sequencer #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .DIV_W(DIV_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_begin(req_begin), .req_end(req_end),
    .req_nbits(req_nbits), .half_div(half_div),
    .tick(tick), .tx_bit(tx_bit),
    .run(run), .div_q(div_q), .load(load), .adv(adv), .sample(sample),
    .busy(busy), .done(done), .ser_clk(ser_clk), .ser_out(ser_out)
  );

  half_bit_pacer #(.DIV_W(DIV_W)) pace_i (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
  );

  bit_shuttle #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) shuttle_i (
    .clk(clk), .rst_n(rst_n), .load(load), .tx_data(tx_data),
    .adv(adv), .sample(sample), .ser_in(ser_in),
    .tx_bit(tx_bit), .rx_q(rx_data), .byte_stb(rx_byte_stb)
  );

  // a request seen while a frame runs leaves the loaders untouched
  assert_busy_ignores_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |-> !load);
endmodule

// File: tb/framed_serial_master_tb_top.sv
module framed_serial_master_tb_top;
  localparam int MAXB  = 32;
  localparam int CNTW  = 6;
  localparam int DIVW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_begin = 1'b0, req_end = 1'b0;
  logic [CNTW-1:0] req_nbits = '0;
  logic [MAXB-1:0] tx_data = '0;
  logic [DIVW-1:0] half_div = '0;
  logic busy, done, rx_byte_stb, ser_clk, ser_out;
  logic ser_in = 1'b0;
  logic [MAXB-1:0] rx_data;

  always #5 clk = ~clk;

  framed_serial_master #(.MAX_BYTES(4), .DIV_W(DIVW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_begin(req_begin),
    .req_end(req_end), .req_nbits(req_nbits), .tx_data(tx_data),
    .half_div(half_div), .busy(busy), .done(done), .rx_data(rx_data),
    .rx_byte_stb(rx_byte_stb), .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // line monitor (peripheral model), sampled at the falling system edge
  int b_cur, n_cur, h_cur;
  logic [MAXB-1:0] resp_cur;
  int pulses, starts, stops, rise_idx, hi_cnt, bad_hi, busy_len, idle_bad;
  int bytes, done_cnt, done_bad;
  logic [63:0] tx_cap;
  bit in_data;
  logic prv_clk = 1'b0, prv_out = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (ser_clk && !prv_clk) begin
      int k;
      k = rise_idx - b_cur;
      in_data = (rise_idx >= b_cur) && (k < n_cur);
      if (in_data) begin
        tx_cap = {tx_cap[62:0], ser_out};
        ser_in = resp_cur[MAXB-1-k];
      end
      hi_cnt = 1;
      rise_idx++;
      pulses++;
    end else if (ser_clk && prv_clk) begin
      hi_cnt++;
      if (!prv_out && ser_out) starts++;
      if (prv_out && !ser_out) stops++;
    end else if (!ser_clk && prv_clk) begin
      if (in_data && hi_cnt != h_cur) bad_hi++;
      in_data = 1'b0;
    end
    if (busy) busy_len++;
    if (!busy && (ser_clk || ser_out)) idle_bad++;
    if (rx_byte_stb) bytes++;
    if (done) begin
      done_cnt++;
      if (busy) done_bad++;
    end
    prv_clk = ser_clk;
    prv_out = ser_out;
  end

  bit hung = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    hung = 1'b1;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic check_reset();
    @(negedge clk); #2;
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!ser_clk && !ser_out, "R1 reset lines", {ser_clk, ser_out}, 0);
    chk(rx_data == '0, "R1 reset rx_data", rx_data, 0);
  endtask

  task automatic run_frame(input string tag, input bit b, input bit e, input int n,
                           input logic [MAXB-1:0] tx, input logic [MAXB-1:0] resp,
                           input int div, input bit poke);
    int ne, exp_len;
    logic [63:0] exp_tx, mask;
    ne = (n > MAXB) ? MAXB : n;
    @(negedge clk); #2;
    b_cur = b; n_cur = ne; h_cur = div + 1; resp_cur = resp;
    pulses = 0; starts = 0; stops = 0; rise_idx = 0; bad_hi = 0; busy_len = 0;
    idle_bad = 0; bytes = 0; done_cnt = 0; done_bad = 0; tx_cap = '0; in_data = 1'b0;
    req_begin = b; req_end = e; req_nbits = CNTW'(n); tx_data = tx;
    half_div = DIVW'(div); req_valid = 1'b1;
    @(negedge clk); #2;
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #2;
      req_valid = 1'b1; req_begin = ~b; req_end = ~e; req_nbits = 6'd5;
      tx_data = ~tx; half_div = 8'd0;
      @(negedge clk); #2;
      req_valid = 1'b0;
    end
    while (done_cnt == 0 && !hung) begin
      @(negedge clk); #2;
    end
    repeat (3) @(negedge clk);
    #2;
    exp_len = (2 * b + 2 * ne + 3 * e) * (div + 1) + 1;
    mask    = (ne == 0) ? 64'd0 : (((64'd1 << ne) - 1) << (MAXB - ne));
    exp_tx  = (ne == 0) ? 64'd0 : ((64'(tx) >> (MAXB - ne)) & ((64'd1 << ne) - 1));
    chk(pulses == ne + b + e, {tag, " R7 clock pulses"}, pulses, ne + b + e);
    chk(starts == b, {tag, " R2 start marks"}, starts, b);
    chk(stops == e, {tag, " R6 stop marks"}, stops, e);
    chk(tx_cap == exp_tx, {tag, " R3 bits sent MSB first"}, tx_cap, exp_tx);
    chk(bad_hi == 0, {tag, " R3 data clock-high length"}, bad_hi, 0);
    chk(64'(rx_data) == (64'(resp) & mask), {tag, " R4 received bits"}, rx_data, 64'(resp) & mask);
    chk(bytes == ne / 8, {tag, " R5 byte strobes"}, bytes, ne / 8);
    chk(busy_len == exp_len, {tag, " R9 busy length"}, busy_len, exp_len);
    chk(done_cnt == 1 && done_bad == 0, {tag, " R9 single done after busy"}, done_cnt, 1);
    chk(idle_bad == 0, {tag, " R1 lines low while idle"}, idle_bad, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_reset();
    run_frame("reg16",  1, 1, 16, 32'hA5C3_0000, 32'h3C5A_0000, 1, 0);
    run_frame("cmd8",   1, 1,  8, 32'h9F00_0000, 32'hFF00_0000, 0, 0);
    run_frame("b24",    1, 1, 24, 32'h1234_5600, 32'hC0FF_EE00, 3, 0);
    run_frame("zero",   1, 1,  0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 0);
    run_frame("R11 open",  1, 0,  8, 32'h8100_0000, 32'h7E00_0000, 2, 0);
    run_frame("R11 close", 0, 1, 12, 32'hF0F0_0000, 32'h5A50_0000, 2, 0);
    run_frame("R8 clamp", 1, 1, 40, 32'hDEAD_BEEF, 32'h0123_4567, 0, 0);
    run_frame("R10 poke", 1, 1, 16, 32'h55AA_0000, 32'hAA55_0000, 2, 1);
    run_frame("bare5",  0, 0,  5, 32'hB800_0000, 32'hF800_0000, 0, 0);
    run_frame("last",   0, 0, 32, 32'h8000_0001, 32'h0000_0001, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule